// File: doc/BRIEF.md
# CAN Mailbox Transmit Scheduler

This block decides which mailbox of a CAN controller's message bank goes out on the bus next. Software drives it through a small register window. Per-bank vectors enable mailboxes and choose their direction. A write-one-to-set port raises transmit requests and a write-one port withdraws them. Two write-one-to-clear vectors report completed and aborted transmissions. Every mailbox also owns a control word that holds a 6-bit transmit priority, a remote-frame flag and a 4-bit data length code.

A mailbox is a candidate when it is enabled, set to transmit and has a pending request. The scheduler picks the candidate with the largest priority value. When priorities are equal, the higher mailbox number wins. It hands that mailbox's index, priority, remote flag and length code to an external bit-level protocol engine, along with a one-cycle start strobe.

The selection stays fixed until the engine signals success or abort. That signal clears the request and sets the matching flag in the completion or abort vector. The bit stream, bit timing and reception are handled elsewhere.

Top module: `can_tx_sched`

## Requirements
- R1: After reset, every register vector and every control word reads as zero, `tx_start` is low and `tx_mbox` is 0.
- R2: Writing word address 2 marks as pending each mailbox whose data bit is 1. Data bits at 0 leave the pending state unchanged. Reading address 2 or 3 returns the pending vector.
- R3: A mailbox is sent only if its bit in the enable vector (address 0) is 1 and its bit in the direction vector (address 1) is 0. A direction bit of 1 means receive, and such a mailbox is never started.
- R4: Among the candidates, the one with the numerically largest priority field (0 to 0x3F) is started first.
- R5: Among candidates that share the largest priority, the highest-numbered mailbox is started first.
- R6: When `eng_done` is high while a frame is in flight, that mailbox's pending bit clears and its bit in the completion vector (address 4) sets. Writing 1 to an address-4 bit clears it, and writing 0 has no effect. The same write-one-to-clear rule applies to the abort vector (address 5).
- R7: Writing 1 to address 3 for a pending mailbox that is not in flight clears its request and sets its abort bit (address 5). The same write for the mailbox in flight has no effect.
- R8: When `eng_abort` is high while a frame is in flight, that mailbox's pending bit clears and its abort bit sets. Its completion bit stays clear.
- R9: `tx_start` is high for exactly one cycle. While a frame is in flight, `tx_mbox` is held and no new start occurs, even if a higher-priority request arrives. The next start comes on the cycle after the cycle that follows done or abort.
- R10: With no candidate, `tx_start` stays low and `tx_mbox` keeps its last value.
- R11: The control word of mailbox k is at address 32+k. It holds the priority in bits 13:8, the remote flag in bit 4 and the length code in bits 3:0. `tx_prio`, `tx_rtr` and `tx_dlc` present these fields for the mailbox on `tx_mbox`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | IDX_W+1 (6) | Word address, shared by reads and writes |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Combinational read data for `reg_addr` |
| eng_done | input | 1 | Engine reports successful transmission |
| eng_abort | input | 1 | Engine reports abandoned transmission |
| tx_start | output | 1 | One-cycle strobe that starts a frame |
| tx_mbox | output | IDX_W (5) | Index of the mailbox selected for sending |
| tx_prio | output | 6 | Priority field of the selected mailbox |
| tx_rtr | output | 1 | Remote-frame flag of the selected mailbox |
| tx_dlc | output | 4 | Length code of the selected mailbox |

## Verification
A wrong pending or acknowledge bit shows up on the next register read, one cycle after the causing event. A wrong arbitration tree shows up as the wrong `tx_mbox` on the very next start strobe. The bench therefore loads several mailboxes in one write and checks the full start order, including priority ties and the maximum priority value. A sequencer that leaks out of its busy state shows up as a second strobe or a changed index while a frame is in flight. The bench checks for this across several idle cycles, and across request and cancel writes that arrive mid-frame.

// File: rtl/can_tx_pkg.sv
package can_tx_pkg;

   localparam int PRIO_W      = 6;
   localparam int DLC_W       = 4;
   localparam int CW_PRIO_LSB = 8;
   localparam int CW_RTR_BIT  = 4;
   localparam int CW_DLC_LSB  = 0;
   localparam int CW_MIN_W    = CW_PRIO_LSB + PRIO_W;

   typedef enum logic [2:0] {
      RG_ENABLE    = 3'd0,
      RG_DIR       = 3'd1,
      RG_REQ_SET   = 3'd2,
      RG_REQ_CLR   = 3'd3,
      RG_DONE_ACK  = 3'd4,
      RG_ABORT_ACK = 3'd5
   } reg_sel_e;

   typedef enum logic {
      SQ_IDLE = 1'b0,
      SQ_BUSY = 1'b1
   } seq_state_e;

endpackage

// File: rtl/can_tx_regs.sv
module can_tx_regs
   import can_tx_pkg::*;
#(
   parameter int NUM_MB = 32,
   parameter int DATA_W = 32,
   parameter int IDX_W  = $clog2(NUM_MB),
   parameter int ADDR_W = IDX_W + 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       reg_wr,
   input  logic [ADDR_W-1:0]          reg_addr,
   input  logic [DATA_W-1:0]          reg_wdata,
   output logic [DATA_W-1:0]          reg_rdata,
   input  logic                       busy,
   input  logic [IDX_W-1:0]           sel_idx,
   input  logic                       fin_valid,
   input  logic                       fin_ok,
   output logic [NUM_MB-1:0]          cand,
   output logic [NUM_MB*PRIO_W-1:0]   prio_flat,
   output logic [PRIO_W-1:0]          sel_prio,
   output logic                       sel_rtr,
   output logic [DLC_W-1:0]           sel_dlc
);

   localparam logic [NUM_MB-1:0] ONE_MB = {{(NUM_MB-1){1'b0}}, 1'b1};

   logic [NUM_MB-1:0]       en_q, dir_q, pend_q, dack_q, aack_q;
   logic [NUM_MB-1:0]       rtr_vec;
   logic [NUM_MB*DLC_W-1:0] dlc_flat;

   reg_sel_e          rsel;
   logic              vec_hit, cw_hit;
   logic [IDX_W-1:0]  ridx;
   logic [NUM_MB-1:0] wdata_mb;
   logic [NUM_MB-1:0] set_mask, clr_req, w1c_done, w1c_abort;
   logic [NUM_MB-1:0] inflight_mask, cancel_mask, fin_mask;

   assign rsel     = reg_sel_e'(reg_addr[2:0]);
   assign ridx     = reg_addr[IDX_W-1:0];
   assign cw_hit   = reg_wr && reg_addr[ADDR_W-1];
   assign vec_hit  = reg_wr && !reg_addr[ADDR_W-1] && (reg_addr[IDX_W-1:3] == '0);
   assign wdata_mb = reg_wdata[NUM_MB-1:0];

   assign set_mask  = (vec_hit && rsel == RG_REQ_SET)   ? wdata_mb : '0;
   assign clr_req   = (vec_hit && rsel == RG_REQ_CLR)   ? wdata_mb : '0;
   assign w1c_done  = (vec_hit && rsel == RG_DONE_ACK)  ? wdata_mb : '0;
   assign w1c_abort = (vec_hit && rsel == RG_ABORT_ACK) ? wdata_mb : '0;

   assign inflight_mask = busy ? (ONE_MB << sel_idx) : '0;
   assign cancel_mask   = clr_req & pend_q & ~inflight_mask;
   assign fin_mask      = fin_valid ? (ONE_MB << sel_idx) : '0;

   // A cancel that lands in the same cycle as a launch decision wins.
   assign cand = en_q & ~dir_q & pend_q & ~cancel_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         dir_q  <= '0;
         pend_q <= '0;
         dack_q <= '0;
         aack_q <= '0;
      end else begin
         if (vec_hit && rsel == RG_ENABLE) en_q  <= wdata_mb;
         if (vec_hit && rsel == RG_DIR)    dir_q <= wdata_mb;
         pend_q <= (pend_q & ~cancel_mask & ~fin_mask) | set_mask;
         dack_q <= (dack_q & ~w1c_done) | (fin_ok ? fin_mask : '0);
         aack_q <= (aack_q & ~w1c_abort) | cancel_mask | (fin_ok ? '0 : fin_mask);
      end
   end

   // Per-mailbox control word storage
   for (genvar k = 0; k < NUM_MB; k++) begin : g_mb
      logic [PRIO_W-1:0] prio_r;
      logic              rtr_r;
      logic [DLC_W-1:0]  dlc_r;
      logic              hit;

      assign hit = cw_hit && (ridx == IDX_W'(k));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prio_r <= '0;
            rtr_r  <= 1'b0;
            dlc_r  <= '0;
         end else if (hit) begin
            prio_r <= reg_wdata[CW_PRIO_LSB +: PRIO_W];
            rtr_r  <= reg_wdata[CW_RTR_BIT];
            dlc_r  <= reg_wdata[CW_DLC_LSB +: DLC_W];
         end
      end

      assign prio_flat[k*PRIO_W +: PRIO_W] = prio_r;
      assign rtr_vec[k]                    = rtr_r;
      assign dlc_flat[k*DLC_W +: DLC_W]    = dlc_r;
   end

   assign sel_prio = prio_flat[sel_idx*PRIO_W +: PRIO_W];
   assign sel_rtr  = rtr_vec[sel_idx];
   assign sel_dlc  = dlc_flat[sel_idx*DLC_W +: DLC_W];

   always_comb begin
      reg_rdata = '0;
      if (reg_addr[ADDR_W-1]) begin
         reg_rdata[CW_PRIO_LSB +: PRIO_W] = prio_flat[ridx*PRIO_W +: PRIO_W];
         reg_rdata[CW_RTR_BIT]            = rtr_vec[ridx];
         reg_rdata[CW_DLC_LSB +: DLC_W]   = dlc_flat[ridx*DLC_W +: DLC_W];
      end else if (reg_addr[IDX_W-1:3] == '0) begin
         case (rsel)
            RG_ENABLE:    reg_rdata[NUM_MB-1:0] = en_q;
            RG_DIR:       reg_rdata[NUM_MB-1:0] = dir_q;
            RG_REQ_SET,
            RG_REQ_CLR:   reg_rdata[NUM_MB-1:0] = pend_q;
            RG_DONE_ACK:  reg_rdata[NUM_MB-1:0] = dack_q;
            RG_ABORT_ACK: reg_rdata[NUM_MB-1:0] = aack_q;
            default:      reg_rdata = '0;
         endcase
      end
   end

   // R2: a set write always leaves its bits pending
   a_r2_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (set_mask != '0) |=> ((pend_q & $past(set_mask)) == $past(set_mask)));

   // R6: completion bits appear only on an engine done
   a_r6_done_source: assert property (@(posedge clk) disable iff (!rst_n)
      !(fin_valid && fin_ok) |=> ((dack_q & ~$past(dack_q)) == '0));

   // R7 / R8: abort bits appear only on a cancel or an engine abort
   a_r7_abort_source: assert property (@(posedge clk) disable iff (!rst_n)
      (!(fin_valid && !fin_ok) && (clr_req == '0)) |=> ((aack_q & ~$past(aack_q)) == '0));

   // R9: the mailbox in flight keeps its request until the engine finishes
   a_r9_inflight_pending: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> pend_q[sel_idx]);

endmodule

// File: rtl/can_tx_arb.sv
module can_tx_arb
   import can_tx_pkg::*;
#(
   parameter int NUM_MB = 32,
   parameter int IDX_W  = $clog2(NUM_MB)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_MB-1:0]        cand,
   input  logic [NUM_MB*PRIO_W-1:0] prio_flat,
   output logic                     win_valid,
   output logic [IDX_W-1:0]         win_idx,
   output logic [PRIO_W-1:0]        win_prio
);

   localparam int NODES = 2 * NUM_MB;

   // Heap-ordered tournament tree: leaves at NUM_MB..2*NUM_MB-1 in mailbox
   // order, so the right child always covers the higher mailbox numbers.
   logic              nv [NODES];
   logic [PRIO_W-1:0] np [NODES];
   logic [IDX_W-1:0]  ni [NODES];

   always_comb begin
      nv[0] = 1'b0;
      np[0] = '0;
      ni[0] = '0;
      for (int k = 0; k < NUM_MB; k++) begin
         nv[NUM_MB+k] = cand[k];
         np[NUM_MB+k] = prio_flat[k*PRIO_W +: PRIO_W];
         ni[NUM_MB+k] = IDX_W'(k);
      end
      for (int i = NUM_MB - 1; i >= 1; i--) begin
         if (nv[2*i+1] && (!nv[2*i] || np[2*i+1] >= np[2*i])) begin
            nv[i] = nv[2*i+1];
            np[i] = np[2*i+1];
            ni[i] = ni[2*i+1];
         end else begin
            nv[i] = nv[2*i];
            np[i] = np[2*i];
            ni[i] = ni[2*i];
         end
      end
   end

   assign win_valid = nv[1];
   assign win_idx   = ni[1];
   assign win_prio  = np[1];

   // R3: the winner is always a candidate
   a_r3_win_is_cand: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid |-> cand[win_idx]);

   for (genvar k = 0; k < NUM_MB; k++) begin : g_chk
      // R4: no candidate outranks the winner
      a_r4_no_higher: assert property (@(posedge clk) disable iff (!rst_n)
         cand[k] |-> (win_valid && prio_flat[k*PRIO_W +: PRIO_W] <= win_prio));
      // R5: on equal priority the winner has the larger number
      a_r5_tie_high: assert property (@(posedge clk) disable iff (!rst_n)
         (cand[k] && prio_flat[k*PRIO_W +: PRIO_W] == win_prio) |-> (IDX_W'(k) <= win_idx));
   end

endmodule

// File: rtl/can_tx_seq.sv
module can_tx_seq
   import can_tx_pkg::*;
#(
   parameter int NUM_MB = 32,
   parameter int IDX_W  = $clog2(NUM_MB)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             win_valid,
   input  logic [IDX_W-1:0] win_idx,
   input  logic             eng_done,
   input  logic             eng_abort,
   output logic             busy,
   output logic [IDX_W-1:0] sel_idx,
   output logic             tx_start,
   output logic             fin_valid,
   output logic             fin_ok
);

   seq_state_e       state_q;
   logic [IDX_W-1:0] sel_q;
   logic             start_q;

   assign busy      = (state_q == SQ_BUSY);
   assign fin_valid = busy && (eng_done || eng_abort);
   assign fin_ok    = busy && eng_done;
   assign sel_idx   = sel_q;
   assign tx_start  = start_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         sel_q   <= '0;
         start_q <= 1'b0;
      end else begin
         start_q <= 1'b0;
         case (state_q)
            SQ_IDLE: begin
               if (win_valid) begin
                  state_q <= SQ_BUSY;
                  sel_q   <= win_idx;
                  start_q <= 1'b1;
               end
            end
            SQ_BUSY: begin
               if (fin_valid) state_q <= SQ_IDLE;
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   // R9: the strobe is a single cycle and only appears while busy
   a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start |=> !tx_start);
   a_r9_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start |-> busy);
   // R9: selection frozen while in flight
   a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !fin_valid) |=> (busy && $stable(sel_q) && !tx_start));
   // R10: nothing to send leaves index and strobe alone
   a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !win_valid) |=> ($stable(sel_q) && !tx_start));

endmodule

// File: rtl/can_tx_sched.sv
module can_tx_sched
   import can_tx_pkg::*;
#(
   parameter  int NUM_MB = 32,
   parameter  int DATA_W = 32,
   localparam int IDX_W  = $clog2(NUM_MB),
   localparam int ADDR_W = IDX_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              eng_done,
   input  logic              eng_abort,
   output logic              tx_start,
   output logic [IDX_W-1:0]  tx_mbox,
   output logic [PRIO_W-1:0] tx_prio,
   output logic              tx_rtr,
   output logic [DLC_W-1:0]  tx_dlc
);

   // Elaboration-time parameter checks
   if (NUM_MB < 16 || (NUM_MB & (NUM_MB - 1)) != 0) begin : g_bad_num_mb
      $error("can_tx_sched: NUM_MB must be a power of two of at least 16");
   end
   if (NUM_MB > DATA_W) begin : g_bad_data_w
      $error("can_tx_sched: DATA_W must hold one bit per mailbox");
   end
   if (DATA_W < CW_MIN_W) begin : g_bad_cw_w
      $error("can_tx_sched: DATA_W too narrow for the control word");
   end

   logic                     busy, fin_valid, fin_ok, win_valid;
   logic [IDX_W-1:0]         sel_idx, win_idx;
   logic [PRIO_W-1:0]        win_prio;
   logic [NUM_MB-1:0]        cand;
   logic [NUM_MB*PRIO_W-1:0] prio_flat;

   can_tx_regs #(
      .NUM_MB (NUM_MB),
      .DATA_W (DATA_W),
      .IDX_W  (IDX_W),
      .ADDR_W (ADDR_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .busy      (busy),
      .sel_idx   (sel_idx),
      .fin_valid (fin_valid),
      .fin_ok    (fin_ok),
      .cand      (cand),
      .prio_flat (prio_flat),
      .sel_prio  (tx_prio),
      .sel_rtr   (tx_rtr),
      .sel_dlc   (tx_dlc)
   );

   can_tx_arb #(
      .NUM_MB (NUM_MB),
      .IDX_W  (IDX_W)
   ) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .cand      (cand),
      .prio_flat (prio_flat),
      .win_valid (win_valid),
      .win_idx   (win_idx),
      .win_prio  (win_prio)
   );

   can_tx_seq #(
      .NUM_MB (NUM_MB),
      .IDX_W  (IDX_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .win_valid (win_valid),
      .win_idx   (win_idx),
      .eng_done  (eng_done),
      .eng_abort (eng_abort),
      .busy      (busy),
      .sel_idx   (sel_idx),
      .tx_start  (tx_start),
      .fin_valid (fin_valid),
      .fin_ok    (fin_ok)
   );

   assign tx_mbox = sel_idx;

   // R8: an engine abort never counts as a completion
   a_r8_abort_not_done: assert property (@(posedge clk) disable iff (!rst_n)
      (fin_valid && !fin_ok) |-> !eng_done);

endmodule

// File: tb/can_tx_sched_tb.sv
`timescale 1ns/1ps
module can_tx_sched_tb;

   localparam int NUM_MB = 32;
   localparam int DATA_W = 32;
   localparam logic [5:0] A_EN = 6'd0, A_DIR = 6'd1, A_SET = 6'd2,
                          A_CLR = 6'd3, A_DACK = 6'd4, A_AACK = 6'd5;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [5:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        eng_done = 1'b0, eng_abort = 1'b0;
   logic        tx_start, tx_rtr;
   logic [4:0]  tx_mbox;
   logic [5:0]  tx_prio;
   logic [3:0]  tx_dlc;

   int n_chk = 0, n_err = 0;

   always #2 clk = ~clk;

   can_tx_sched #(.NUM_MB(NUM_MB), .DATA_W(DATA_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_done(eng_done),
      .eng_abort(eng_abort), .tx_start(tx_start), .tx_mbox(tx_mbox),
      .tx_prio(tx_prio), .tx_rtr(tx_rtr), .tx_dlc(tx_dlc));

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_chk(input logic [5:0] a, input logic [31:0] exp,
                         input string req, input string what);
      @(negedge clk);
      reg_addr = a;
      #1;
      chk(req, what, reg_rdata, exp);
   endtask

   task automatic set_cw(input int k, input logic [5:0] p, input logic r,
                         input logic [3:0] d);
      wr(6'(32 + k), {18'b0, p, 3'b0, r, d});
   endtask

   task automatic expect_start(input int idx, input string req);
      bit seen = 1'b0;
      for (int c = 0; c < 4 && !seen; c++) begin
         @(negedge clk);
         if (tx_start) seen = 1'b1;
      end
      chk(req, "start strobe seen", 32'(seen), 32'd1);
      chk(req, "started mailbox", 32'(tx_mbox), 32'(idx));
      @(negedge clk);
      chk("R9", "strobe width one cycle", 32'(tx_start), 32'd0);
   endtask

   task automatic expect_quiet(input int n, input string req);
      bit seen = 1'b0;
      for (int c = 0; c < n; c++) begin
         @(negedge clk);
         if (tx_start) seen = 1'b1;
      end
      chk(req, "no start strobe", 32'(seen), 32'd0);
   endtask

   task automatic pulse_done();
      @(negedge clk); eng_done = 1'b1;
      @(negedge clk); eng_done = 1'b0;
   endtask

   task automatic pulse_abort();
      @(negedge clk); eng_abort = 1'b1;
      @(negedge clk); eng_abort = 1'b0;
   endtask

   task automatic clean_up();
      wr(A_CLR, '1); wr(A_DACK, '1); wr(A_AACK, '1);
      wr(A_EN, '0); wr(A_DIR, '0);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R1", "tx_start in reset", 32'(tx_start), 32'd0);
      chk("R1", "tx_mbox in reset", 32'(tx_mbox), 32'd0);
      rst_n = 1'b1;
      for (int a = 0; a < 6; a++) rd_chk(6'(a), 32'd0, "R1", "vector after reset");
      rd_chk(6'd45, 32'd0, "R1", "control word after reset");
   endtask

   task automatic t_set_and_gate();
      set_cw(6, 6'd40, 1'b0, 4'd3);
      wr(A_SET, (32'd1 << 6) | (32'd1 << 12));
      rd_chk(A_SET, 32'h0000_1040, "R2", "pending after set");
      wr(A_SET, 32'd0);
      rd_chk(A_CLR, 32'h0000_1040, "R2", "pending after zero write");
      expect_quiet(5, "R3");
      wr(A_DIR, 32'h0000_1040);
      wr(A_EN, 32'h0000_1040);
      expect_quiet(5, "R3");
      wr(A_DIR, 32'h0000_1000);
      expect_start(6, "R3");
      chk("R11", "tx_prio", 32'(tx_prio), 32'd40);
      chk("R11", "tx_dlc", 32'(tx_dlc), 32'd3);
      pulse_done();
      expect_quiet(5, "R3");
      rd_chk(A_DACK, 32'h0000_0040, "R6", "completion bit");
      rd_chk(A_SET, 32'h0000_1000, "R6", "pending after done");
      wr(A_CLR, 32'h0000_1000);
      rd_chk(A_AACK, 32'h0000_1000, "R7", "abort bit after cancel");
      rd_chk(A_SET, 32'd0, "R7", "pending after cancel");
      wr(A_AACK, 32'd0);
      rd_chk(A_AACK, 32'h0000_1000, "R6", "abort vector after zero write");
      wr(A_DACK, 32'd0);
      rd_chk(A_DACK, 32'h0000_0040, "R6", "completion after zero write");
      wr(A_AACK, '1);
      wr(A_DACK, 32'h0000_0040);
      rd_chk(A_AACK, 32'd0, "R6", "abort vector cleared");
      rd_chk(A_DACK, 32'd0, "R6", "completion cleared");
      clean_up();
   endtask

   task automatic t_prio();
      set_cw(1, 6'h3F, 1'b1, 4'd8);
      set_cw(3, 6'd5, 1'b0, 4'd2);
      set_cw(7, 6'd20, 1'b0, 4'd15);
      wr(A_EN, 32'h0000_008A);
      wr(A_SET, 32'h0000_008A);
      expect_start(1, "R4");
      chk("R11", "tx_prio max", 32'(tx_prio), 32'h3F);
      chk("R11", "tx_rtr", 32'(tx_rtr), 32'd1);
      chk("R11", "tx_dlc", 32'(tx_dlc), 32'd8);
      pulse_done();
      expect_start(7, "R4");
      chk("R11", "tx_dlc 15", 32'(tx_dlc), 32'd15);
      chk("R11", "tx_rtr clear", 32'(tx_rtr), 32'd0);
      pulse_done();
      expect_start(3, "R4");
      pulse_done();
      expect_quiet(4, "R10");
      rd_chk(A_DACK, 32'h0000_008A, "R6", "all completions");
      rd_chk(6'd33, 32'h0000_3F18, "R11", "control word layout");
      clean_up();
   endtask

   task automatic t_tie();
      set_cw(0, 6'd10, 1'b0, 4'd1);
      set_cw(2, 6'd10, 1'b0, 4'd1);
      set_cw(9, 6'd10, 1'b0, 4'd1);
      set_cw(30, 6'd10, 1'b0, 4'd1);
      set_cw(31, 6'd9, 1'b0, 4'd1);
      wr(A_EN, 32'hC000_0205);
      wr(A_SET, 32'hC000_0205);
      expect_start(30, "R5");
      pulse_done();
      expect_start(9, "R5");
      pulse_done();
      expect_start(2, "R5");
      pulse_done();
      expect_start(0, "R5");
      pulse_done();
      expect_start(31, "R4");
      pulse_done();
      expect_quiet(4, "R10");
      clean_up();
   endtask

   task automatic t_frozen();
      set_cw(4, 6'd1, 1'b0, 4'd4);
      set_cw(5, 6'd50, 1'b0, 4'd5);
      wr(A_EN, 32'h0000_0030);
      wr(A_SET, 32'h0000_0010);
      expect_start(4, "R9");
      wr(A_SET, 32'h0000_0020);
      expect_quiet(6, "R9");
      chk("R9", "index frozen in flight", 32'(tx_mbox), 32'd4);
      pulse_done();
      expect_start(5, "R9");
      pulse_done();
      expect_quiet(3, "R10");
      clean_up();
   endtask

   task automatic t_cancel();
      set_cw(8, 6'd3, 1'b0, 4'd0);
      set_cw(9, 6'd60, 1'b0, 4'd0);
      wr(A_EN, 32'h0000_0300);
      wr(A_SET, 32'h0000_0100);
      expect_start(8, "R7");
      wr(A_SET, 32'h0000_0200);
      wr(A_CLR, 32'h0000_0200);
      rd_chk(A_SET, 32'h0000_0100, "R7", "pending after cancel of waiting");
      rd_chk(A_AACK, 32'h0000_0200, "R7", "abort bit of waiting");
      wr(A_CLR, 32'h0000_0100);
      rd_chk(A_SET, 32'h0000_0100, "R7", "in-flight request kept");
      rd_chk(A_AACK, 32'h0000_0200, "R7", "no abort for in-flight");
      pulse_done();
      expect_quiet(6, "R10");
      chk("R10", "index held with no candidate", 32'(tx_mbox), 32'd8);
      rd_chk(A_DACK, 32'h0000_0100, "R6", "completion of in-flight");
      clean_up();
   endtask

   task automatic t_abort();
      set_cw(11, 6'd7, 1'b0, 4'd6);
      wr(A_EN, 32'h0000_0800);
      wr(A_SET, 32'h0000_0800);
      expect_start(11, "R8");
      pulse_abort();
      expect_quiet(4, "R8");
      rd_chk(A_AACK, 32'h0000_0800, "R8", "abort bit from engine");
      rd_chk(A_DACK, 32'd0, "R8", "no completion on abort");
      rd_chk(A_SET, 32'd0, "R8", "pending cleared on abort");
      clean_up();
   endtask

   initial begin
      #(200000 * 4);
      n_chk++;
      n_err++;
      $display("FAIL R9 watchdog: actual running expected finished");
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_set_and_gate();
      t_prio();
      t_tie();
      t_frozen();
      t_cancel();
      t_abort();
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule